// File: doc/BRIEF.md
# Status Readback Shift Register

This block holds the serial shift register of an LED-driver style device and lets the same register send a status snapshot back to the host. In grayscale mode, a latch strobe replaces the shift contents with a 192-bit status packet. The packet holds the open-load flags, the thermal-error flag and a copy of the per-channel correction register. The first packet bit is on the serial output straight after the latch edge. Each later shift pulse moves the next lower bit onto the output and takes a new host bit in at the bottom. The host therefore reads the status back while it sends the next grayscale frame.

The open-load and thermal inputs come from detectors whose outputs settle in a staggered order after the PWM cycle starts. A start pulse marks the first grayscale clock edge, and a setup counter loaded from `setup_cycles` runs down. The flags are registered only when that counter expires. The registered flags feed the packet and drive an active-low error output that is the OR of the open-load flags.

All data moves under one system clock, and `shift_en` qualifies each serial shift. The serial path has no back-pressure: every cycle with `shift_en` high moves one bit, and no shift is ever refused. There is no valid/ready pair, because the host owns the serial clock.

Top module: `status_readback`

## Requirements
- R1: After a synchronous reset, `sdata_out` is 0 and `err_n` is 1.
- R2: When `latch` is high and `mode_dc` is 0, the register loads the status packet on that edge. Packet bit 191 is on `sdata_out` after that edge, with no shift needed.
- R3: On each cycle with `shift_en` high and no load, the register moves up by one bit. `sdata_in` enters at bit 0 and `sdata_out` then shows the next lower bit.
- R4: Packet layout. Bit i (0 to 15) is the sampled open-load flag of channel i. Bit 16 is the sampled thermal flag. Bit 24+k is `dc_data[k]` for k from 0 to 95. Bits 17 to 23 and 120 to 191 are zero.
- R5: While `mode_dc` is 1, `latch` has no effect, and the register is a plain shift path.
- R6: When `latch` (in grayscale mode) and `shift_en` are high in the same cycle, the load wins.
- R7: A `gs_start` pulse loads the setup counter from `setup_cycles`. The flags are registered exactly `setup_cycles`+1 cycles after the pulse. Flag input changes after that edge do not reach the packet.
- R8: `err_n` is 0 exactly when any registered open-load flag is 1, and it changes only at the sampling edge or at reset.
- R9: With no load and no shift, the register contents hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dc | input | 1 | 1 = correction-programming mode, 0 = grayscale mode |
| latch | input | 1 | Latch strobe that commits grayscale data |
| shift_en | input | 1 | Serial clock qualifier, one bit per high cycle |
| sdata_in | input | 1 | Serial data into bit 0 |
| sdata_out | output | 1 | Serial data from bit 191 |
| gs_start | input | 1 | Pulse at the first grayscale clock edge |
| setup_cycles | input | 8 | Setup delay in cycles before flag sampling |
| lod_in | input | 16 | Raw open-load flags, one per channel |
| tef_in | input | 1 | Raw thermal-error flag |
| dc_data | input | 96 | Correction register contents |
| err_n | output | 1 | Active-low error: low when any sampled open-load flag is set |

## Verification
The packet path is tried with several patterns. All-zero flags and correction data show that reserved bits stay low. All-ones correction data with the two edge channels flagged finds bit positions that are off by one at the field edges. Checkerboard data catches swapped or reversed slices, and a single set bit at each end of the correction field pins its orientation. The setup counter is run with zero and non-zero delays, and the flags are changed just after sampling, so an early or late sample shows up on `err_n` and in the packet. A register preloaded with all ones in correction mode tells a real load apart from an ignored latch and from a shift winning over a load.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int unsigned CH_COUNT   = 16;
  localparam int unsigned CORR_WIDTH = 6;
  localparam int unsigned PACKET_W   = 192;
  localparam int unsigned CORR_LSB   = 24;
  localparam int unsigned DELAY_W    = 8;
endpackage

// File: rtl/srb_flag_sampler.sv
module srb_flag_sampler #(
  parameter int unsigned N_CH  = srb_pkg::CH_COUNT,
  parameter int unsigned CNT_W = srb_pkg::DELAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gs_start,
  input  logic [CNT_W-1:0] setup_cycles,
  input  logic [N_CH-1:0]  lod_in,
  input  logic             tef_in,
  output logic [N_CH-1:0]  lod_q,
  output logic             tef_q,
  output logic             err_n
);
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             sample_fire;

  assign sample_fire = armed && (cnt == '0) && !gs_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (gs_start) begin
      cnt   <= setup_cycles;
      armed <= 1'b1;
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lod_q <= '0;
      tef_q <= 1'b0;
      err_n <= 1'b1;
    end else if (sample_fire) begin
      lod_q <= lod_in;
      tef_q <= tef_in;
      err_n <= ~(|lod_in);
    end
  end

  // R1: error output released after reset
  assert_err_released_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> err_n);

  // R7: no sampling while the setup counter is still running
  assert_wait_setup_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt != '0 && !gs_start) |=> ($stable(lod_q) && $stable(tef_q)));

  // R8: error output follows the flags seen at the sampling edge
  assert_err_follows_R8: assert property (@(posedge clk) disable iff (rst)
    sample_fire |=> (err_n == ~(|$past(lod_in))));

  // R8: error output does not move between samples
  assert_err_steady_R8: assert property (@(posedge clk) disable iff (rst)
    !sample_fire |=> $stable(err_n));
endmodule

// File: rtl/srb_packet_builder.sv
module srb_packet_builder #(
  parameter int unsigned N_CH     = srb_pkg::CH_COUNT,
  parameter int unsigned DC_W     = srb_pkg::CORR_WIDTH,
  parameter int unsigned PKT_W    = srb_pkg::PACKET_W,
  parameter int unsigned DC_LSB   = srb_pkg::CORR_LSB,
  localparam int unsigned DC_BITS = N_CH * DC_W,
  localparam int unsigned TEF_POS = N_CH
) (
  input  logic [N_CH-1:0]    lod_q,
  input  logic               tef_q,
  input  logic [DC_BITS-1:0] dc_data,
  output logic [PKT_W-1:0]   packet
);
  logic [PKT_W-1:0] chan_bits;
  logic [PKT_W-1:0] dc_bits;
  logic [PKT_W-1:0] tef_bits;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    always_comb begin
      chan_bits[ch] = lod_q[ch];
    end
  end
  assign chan_bits[PKT_W-1:N_CH] = '0;

  for (genvar k = 0; k < PKT_W; k++) begin : g_field
    if (k >= DC_LSB && k < DC_LSB + DC_BITS) begin : g_dc
      assign dc_bits[k] = dc_data[k-DC_LSB];
    end else begin : g_zero
      assign dc_bits[k] = 1'b0;
    end
    if (k == TEF_POS) begin : g_tef
      assign tef_bits[k] = tef_q;
    end else begin : g_notef
      assign tef_bits[k] = 1'b0;
    end
  end

  assign packet = chan_bits | dc_bits | tef_bits;
endmodule

// File: rtl/srb_shift_reg.sv
module srb_shift_reg #(
  parameter int unsigned W = srb_pkg::PACKET_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sin,
  output logic         sout
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (load)     sreg <= load_val;
    else if (shift_en) sreg <= {sreg[W-2:0], sin};
  end

  assign sout = sreg[W-1];

  // R2 / R6: a load takes the whole packet, even with a shift pending
  assert_load_takes_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (sreg == $past(load_val)));

  // R3: one-bit move with the new bit at the bottom
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load) |=> (sreg == {$past(sreg[W-2:0]), $past(sin)}));

  // R9: idle cycles leave the register untouched
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load) |=> $stable(sreg));
endmodule

// File: rtl/status_readback.sv
module status_readback #(
  parameter int unsigned N_CH   = srb_pkg::CH_COUNT,
  parameter int unsigned DC_W   = srb_pkg::CORR_WIDTH,
  parameter int unsigned PKT_W  = srb_pkg::PACKET_W,
  parameter int unsigned DC_LSB = srb_pkg::CORR_LSB,
  parameter int unsigned CNT_W  = srb_pkg::DELAY_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_dc,
  input  logic                 latch,
  input  logic                 shift_en,
  input  logic                 sdata_in,
  output logic                 sdata_out,
  input  logic                 gs_start,
  input  logic [CNT_W-1:0]     setup_cycles,
  input  logic [N_CH-1:0]      lod_in,
  input  logic                 tef_in,
  input  logic [N_CH*DC_W-1:0] dc_data,
  output logic                 err_n
);
  logic [N_CH-1:0]  lod_q;
  logic             tef_q;
  logic [PKT_W-1:0] packet;
  logic             load_pkt;

  assign load_pkt = latch && !mode_dc;

  srb_flag_sampler #(.N_CH(N_CH), .CNT_W(CNT_W)) u_sampler (
    .clk(clk), .rst(rst), .gs_start(gs_start), .setup_cycles(setup_cycles),
    .lod_in(lod_in), .tef_in(tef_in), .lod_q(lod_q), .tef_q(tef_q), .err_n(err_n)
  );

  srb_packet_builder #(.N_CH(N_CH), .DC_W(DC_W), .PKT_W(PKT_W), .DC_LSB(DC_LSB)) u_builder (
    .lod_q(lod_q), .tef_q(tef_q), .dc_data(dc_data), .packet(packet)
  );

  srb_shift_reg #(.W(PKT_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_pkt), .load_val(packet),
    .shift_en(shift_en), .sin(sdata_in), .sout(sdata_out)
  );

  // R5: a latch in correction mode leaves the output alone
  assert_dc_latch_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (latch && mode_dc && !shift_en) |=> $stable(sdata_out));

  // R2 / R4: the first bit after a load is the reserved top bit
  assert_first_bit_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (latch && !mode_dc) |=> (sdata_out == 1'b0));
endmodule

// File: tb/test_status_readback.sv
module test_status_readback;
  localparam int unsigned PW = 192;

  logic         clk = 1'b0;
  logic         rst, mode_dc, latch, shift_en, sdata_in, gs_start, tef_in;
  logic [7:0]   setup_cycles;
  logic [15:0]  lod_in;
  logic [95:0]  dc_data;
  logic         sdata_out, err_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  status_readback i_status_readback (
    .clk(clk), .rst(rst), .mode_dc(mode_dc), .latch(latch), .shift_en(shift_en),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .gs_start(gs_start),
    .setup_cycles(setup_cycles), .lod_in(lod_in), .tef_in(tef_in),
    .dc_data(dc_data), .err_n(err_n)
  );

  typedef struct packed {
    logic [15:0] lod;
    logic        tef;
    logic [95:0] dc;
    logic [7:0]  setup;
  } vec_t;

  localparam vec_t VECS [4] = '{
    {16'h0000, 1'b0, 96'h0000_0000_0000_0000_0000_0000, 8'd3},
    {16'h8001, 1'b1, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 8'd0},
    {16'h0000, 1'b1, 96'hA5A5_0123_4567_89AB_CDEF_5A5A, 8'd5},
    {16'h0010, 1'b0, 96'h8000_0000_0000_0000_0000_0001, 8'd2}
  };

  function automatic logic [PW-1:0] expect_pkt(logic [15:0] l, logic t, logic [95:0] d);
    logic [PW-1:0] p = '0;
    for (int i = 0; i < 16; i++) p[i] = l[i];
    p[16] = t;
    for (int k = 0; k < 96; k++) p[24+k] = d[k];
    return p;
  endfunction

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_pkt(input logic [PW-1:0] got, input logic [PW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Read the register out: the current sdata_out is bit 191.
  task automatic read_out(output logic [PW-1:0] got);
    got[PW-1] = sdata_out;
    for (int k = PW - 2; k >= 0; k--) begin
      shift_en = 1'b1;
      @(negedge clk);
      got[k] = sdata_out;
    end
    shift_en = 1'b0;
  endtask

  task automatic shift_in(input logic [PW-1:0] pat);
    for (int k = PW - 1; k >= 0; k--) begin
      sdata_in = pat[k];
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
    sdata_in = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] got;
    logic [PW-1:0] pat;
    logic          prev_err;
    rst = 1'b1; mode_dc = 1'b0; latch = 1'b0; shift_en = 1'b0; sdata_in = 1'b0;
    gs_start = 1'b0; setup_cycles = 8'd0; lod_in = '0; tef_in = 1'b0; dc_data = '0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk_bit(sdata_out, 1'b0, "R1 sdata_out after reset");
    chk_bit(err_n, 1'b1, "R1 err_n after reset");
    prev_err = 1'b1;

    foreach (VECS[v]) begin
      lod_in = VECS[v].lod; tef_in = VECS[v].tef; dc_data = VECS[v].dc;
      setup_cycles = VECS[v].setup;
      gs_start = 1'b1;
      @(negedge clk);
      gs_start = 1'b0;
      repeat (int'(VECS[v].setup)) @(negedge clk);
      chk_bit(err_n, prev_err, "R7 err_n before setup expiry");
      @(negedge clk);
      chk_bit(err_n, ~(|VECS[v].lod), "R8 err_n after sampling");
      prev_err = ~(|VECS[v].lod);
      lod_in = ~VECS[v].lod; tef_in = ~VECS[v].tef;   // R7: late changes must not reach packet
      latch = 1'b1;
      @(negedge clk);
      latch = 1'b0;
      chk_bit(sdata_out, 1'b0, "R2 packet MSB present right after latch");
      read_out(got);
      chk_pkt(got, expect_pkt(VECS[v].lod, VECS[v].tef, VECS[v].dc), "R4 packet layout");
    end

    // R5 / R3: correction mode, latch ignored, plain shift path
    mode_dc = 1'b1;
    pat = {48'hDEAD_BEEF_1234, 48'h0F0F_F0F0_A5A5, 48'h8000_0000_0001, 48'h5555_AAAA_3C3C};
    shift_in(pat);
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
    chk_bit(sdata_out, pat[PW-1], "R5 latch ignored in correction mode");
    read_out(got);
    chk_pkt(got, pat, "R3 serial input reaches output in order");

    // R6: load beats a simultaneous shift; register preloaded with ones
    shift_in({PW{1'b1}});
    mode_dc = 1'b0;
    lod_in = 16'h0204; tef_in = 1'b1; dc_data = 96'h0123_4567_89AB_CDEF_FEDC_BA98;
    setup_cycles = 8'd1;
    gs_start = 1'b1;
    @(negedge clk);
    gs_start = 1'b0;
    repeat (2) @(negedge clk);
    chk_bit(err_n, 1'b0, "R8 err_n low with flagged channels");
    latch = 1'b1; shift_en = 1'b1; sdata_in = 1'b1;
    @(negedge clk);
    latch = 1'b0; shift_en = 1'b0; sdata_in = 1'b0;
    // R9: idle cycles keep the loaded packet
    repeat (10) @(negedge clk);
    read_out(got);
    chk_pkt(got, expect_pkt(16'h0204, 1'b1, 96'h0123_4567_89AB_CDEF_FEDC_BA98),
            "R6 load wins over shift, R9 hold while idle");

    // R1: reset in mid-run
    shift_in({PW{1'b1}});
    do_reset();
    chk_bit(sdata_out, 1'b0, "R1 sdata_out after mid-run reset");
    chk_bit(err_n, 1'b1, "R1 err_n after mid-run reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule